// File: doc/BRIEF.md
# Two-Phase Interleaved PWM with Switch-Current Sharing

This block drives two boost stages that run in parallel. It produces two pulse-width outputs with the same switching period, and the second carrier runs half a period behind the first. An outer regulator supplies one shared duty word. The block splits that word into two duties: a balancing correction is added for the leading phase and subtracted for the lagging phase. The correction keeps the load shared equally between the two stages.

The correction comes from a proportional-integral loop. Its error is the sampled switch current of the leading phase minus that of the lagging phase, and its setpoint is zero. The loop steps only on a separate, slow update strobe, aimed at a bandwidth of a few hundred hertz. Both duties are clamped to a programmable window. Each phase takes a new duty only at the start of its own period. A synchronous halt input forces both outputs low and empties the integrator.

Top module: `interleaved_pwm_share`

## Requirements
- R1: Both outputs repeat every PERIOD clock cycles. The lagging carrier starts PERIOD/2 cycles after the leading one, so a rising edge of pwm_b follows a rising edge of pwm_a by PERIOD/2 cycles. After reset both outputs are low.
- R2: While halt is high, both outputs are low from the next clock on.
- R3: The duty count used by each phase is saturated to the range DMIN to DMAX. A sum above DMAX gives DMAX, and a sum below DMIN gives DMIN.
- R4: The integrator is limited to the range -INT_LIM to +INT_LIM. After a run of large errors, it holds exactly the limit value.
- R5: The correction changes only on a clock where bal_tick or halt is high. A change in the switch currents without a strobe has no effect on either duty.
- R6: A phase takes its new duty only on the clock where its own carrier count is zero. In every period the output is high for exactly the first duty counts, so the high time forms one contiguous run.
- R7: halt sets both the integrator and the correction to zero. After halt is released, both phases run at the plain main duty until the next strobe.
- R8: When neither phase saturates, the sum of the two duties is twice duty_main.
- R9: On each strobe, e = isw_a - isw_b (signed), integ = sat(integ + e, ±INT_LIM), and corr = sat((e >>> KP_SH) + (integ >>> KI_SH), ±CORR_LIM). Phase a uses duty_main + corr and phase b uses duty_main - corr.
- R10: An output is high on a clock exactly when its carrier count on the previous clock was below the duty in force for that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt | input | 1 | Synchronous disable: outputs low, integrator cleared |
| duty_main | input | CNT_W | Shared duty count from the outer loop |
| isw_a | input | CUR_W | Sampled switch current, leading phase (unsigned) |
| isw_b | input | CUR_W | Sampled switch current, lagging phase (unsigned) |
| bal_tick | input | 1 | One-clock strobe that steps the balance loop |
| pwm_a | output | 1 | Leading-phase gate output |
| pwm_b | output | 1 | Lagging-phase gate output |

## Verification
The bench builds the block with a 40-count period and a duty window of 2 to 36. At that size a full carrier cycle takes only a few dozen clocks, and both clamp edges can be reached with small main duties. The loop is built with shifts of 1 and 3, an integrator limit of 64 and a correction limit of 16. A handful of strobes can therefore drive the integrator to its limit. The correction limit is large enough that the integrator's held value can still be read back through the measured high times once the error has returned to zero.

// File: rtl/ipwm_pkg.sv
package ipwm_pkg;

  // Saturate a signed value into [lo, hi].
  function automatic int sat_int(input int v, input int lo, input int hi);
    int r;
    r = v;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

  // True when v falls outside [lo, hi].
  function automatic logic out_of(input int v, input int lo, input int hi);
    return (v > hi) || (v < lo);
  endfunction

  // Signed difference of two unsigned current samples.
  function automatic int cur_diff(input int a, input int b);
    return a - b;
  endfunction

  // Proportional plus integral sum before limiting.
  function automatic int pi_sum(input int e, input int integ,
                                input int kp_sh, input int ki_sh);
    return (e >>> kp_sh) + (integ >>> ki_sh);
  endfunction

endpackage

// File: rtl/ipwm_carrier.sv
module ipwm_carrier #(
  parameter int PERIOD = 2500,
  parameter int CNT_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_lead,
  output logic [CNT_W-1:0] cnt_lag,
  output logic             start_lead,
  output logic             start_lag
);
  localparam int HALF = PERIOD / 2;
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] REST_C = CNT_W'(PERIOD - HALF);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    cnt_lead = cnt_q;
    if (cnt_q >= HALF_C) cnt_lag = cnt_q - HALF_C;
    else                 cnt_lag = cnt_q + REST_C;
  end

  assign start_lead = (cnt_lead == '0);
  assign start_lag  = (cnt_lag == '0);

  // R1: the two period starts never coincide
  a_r1_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_lead, start_lag}));

  // R1: the leading carrier restarts right after its last count
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_lead == LAST) |=> start_lead);

endmodule

// File: rtl/ipwm_balance_pi.sv
module ipwm_balance_pi
  import ipwm_pkg::*;
#(
  parameter int CUR_W    = 12,
  parameter int KP_SH    = 2,
  parameter int KI_SH    = 6,
  parameter int INT_LIM  = 4096,
  parameter int CORR_LIM = 250,
  parameter int INT_W    = 14,
  parameter int CORR_W   = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     halt,
  input  logic                     tick,
  input  logic [CUR_W-1:0]         isw_a,
  input  logic [CUR_W-1:0]         isw_b,
  output logic signed [CORR_W-1:0] corr
);
  logic signed [INT_W-1:0]  integ_q;
  logic signed [CORR_W-1:0] corr_q;
  int err_i;
  int integ_nx;
  int corr_nx;

  always_comb begin
    err_i    = cur_diff(int'(isw_a), int'(isw_b));
    integ_nx = sat_int(int'(integ_q) + err_i, -INT_LIM, INT_LIM);
    corr_nx  = sat_int(pi_sum(err_i, integ_nx, KP_SH, KI_SH), -CORR_LIM, CORR_LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      corr_q  <= '0;
    end else if (halt) begin
      integ_q <= '0;
      corr_q  <= '0;
    end else if (tick) begin
      integ_q <= INT_W'(integ_nx);
      corr_q  <= CORR_W'(corr_nx);
    end
  end

  assign corr = corr_q;

  // R4: integrator never leaves its window
  a_r4_integ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(integ_q) <= INT_LIM) && (int'(integ_q) >= -INT_LIM));

  // R5: correction holds between strobes
  a_r5_corr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !halt) |=> $stable(corr_q));

  // R7: halt empties the loop state
  a_r7_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (integ_q == '0) && (corr_q == '0));

endmodule

// File: rtl/ipwm_duty_split.sv
module ipwm_duty_split
  import ipwm_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int CORR_W = 9,
  parameter int DMIN   = 25,
  parameter int DMAX   = 2375
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         duty_main,
  input  logic signed [CORR_W-1:0] corr,
  output logic [CNT_W-1:0]         duty_lead,
  output logic [CNT_W-1:0]         duty_lag
);
  int  sum_lead;
  int  sum_lag;
  logic sat_lead;
  logic sat_lag;

  always_comb begin
    sum_lead  = int'(duty_main) + int'(corr);
    sum_lag   = int'(duty_main) - int'(corr);
    sat_lead  = out_of(sum_lead, DMIN, DMAX);
    sat_lag   = out_of(sum_lag, DMIN, DMAX);
    duty_lead = CNT_W'(sat_int(sum_lead, DMIN, DMAX));
    duty_lag  = CNT_W'(sat_int(sum_lag, DMIN, DMAX));
  end

  // R3: both duties inside the window
  a_r3_duty_window: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(duty_lead) >= DMIN) && (int'(duty_lead) <= DMAX) &&
    (int'(duty_lag) >= DMIN) && (int'(duty_lag) <= DMAX));

  // R8: unsaturated duties straddle the main duty symmetrically
  a_r8_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_lead && !sat_lag) |->
      (int'(duty_lead) + int'(duty_lag) == 2 * int'(duty_main)));

endmodule

// File: rtl/ipwm_channel.sv
module ipwm_channel #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [CNT_W-1:0] phase_cnt,
  input  logic             start,
  input  logic [CNT_W-1:0] duty_new,
  output logic             pwm
);
  logic [CNT_W-1:0] lat_q;
  logic [CNT_W-1:0] act;
  logic             pwm_q;

  assign act = start ? duty_new : lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (start) lat_q <= duty_new;
      pwm_q <= !halt && (phase_cnt < act);
    end
  end

  assign pwm = pwm_q;

  // R6: duty register moves only at this phase's own period start
  a_r6_latch_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(lat_q));

  // R2: halt forces the gate low
  a_r2_halt_low: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !pwm_q);

endmodule

// File: rtl/interleaved_pwm_share.sv
module interleaved_pwm_share #(
  parameter int PERIOD   = 2500,
  parameter int CNT_W    = $clog2(PERIOD),
  parameter int CUR_W    = 12,
  parameter int DMIN     = 25,
  parameter int DMAX     = 2375,
  parameter int KP_SH    = 2,
  parameter int KI_SH    = 6,
  parameter int INT_LIM  = 4096,
  parameter int CORR_LIM = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic [CNT_W-1:0] duty_main,
  input  logic [CUR_W-1:0] isw_a,
  input  logic [CUR_W-1:0] isw_b,
  input  logic             bal_tick,
  output logic             pwm_a,
  output logic             pwm_b
);
  localparam int INT_W  = $clog2(INT_LIM + 1) + 1;
  localparam int CORR_W = $clog2(CORR_LIM + 1) + 1;
  localparam int NPH    = 2;

  logic [CNT_W-1:0]         ph_cnt [NPH];
  logic                     ph_start [NPH];
  logic [CNT_W-1:0]         ph_duty [NPH];
  logic                     ph_pwm [NPH];
  logic signed [CORR_W-1:0] corr;

  ipwm_carrier #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_carrier (
    .clk(clk), .rst_n(rst_n),
    .cnt_lead(ph_cnt[0]), .cnt_lag(ph_cnt[1]),
    .start_lead(ph_start[0]), .start_lag(ph_start[1])
  );

  ipwm_balance_pi #(
    .CUR_W(CUR_W), .KP_SH(KP_SH), .KI_SH(KI_SH), .INT_LIM(INT_LIM),
    .CORR_LIM(CORR_LIM), .INT_W(INT_W), .CORR_W(CORR_W)
  ) u_pi (
    .clk(clk), .rst_n(rst_n), .halt(halt), .tick(bal_tick),
    .isw_a(isw_a), .isw_b(isw_b), .corr(corr)
  );

  ipwm_duty_split #(
    .CNT_W(CNT_W), .CORR_W(CORR_W), .DMIN(DMIN), .DMAX(DMAX)
  ) u_split (
    .clk(clk), .rst_n(rst_n), .duty_main(duty_main), .corr(corr),
    .duty_lead(ph_duty[0]), .duty_lag(ph_duty[1])
  );

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    ipwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .halt(halt),
      .phase_cnt(ph_cnt[g]), .start(ph_start[g]),
      .duty_new(ph_duty[g]), .pwm(ph_pwm[g])
    );
  end

  assign pwm_a = ph_pwm[0];
  assign pwm_b = ph_pwm[1];

endmodule

// File: tb/interleaved_pwm_share_tb_top.sv
`timescale 1ns/1ps
module interleaved_pwm_share_tb_top;
  localparam int P  = 40;
  localparam int H  = P / 2;
  localparam int CW = $clog2(P);
  localparam int UW = 10;
  localparam int DLO = 2, DHI = 36, KP = 1, KI = 3, IL = 64, CL = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt = 1'b0;
  logic [CW-1:0] duty_main = CW'(20);
  logic [UW-1:0] isw_a = UW'(500);
  logic [UW-1:0] isw_b = UW'(500);
  logic bal_tick = 1'b0;
  logic pwm_a, pwm_b;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  interleaved_pwm_share #(
    .PERIOD(P), .CNT_W(CW), .CUR_W(UW), .DMIN(DLO), .DMAX(DHI),
    .KP_SH(KP), .KI_SH(KI), .INT_LIM(IL), .CORR_LIM(CL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .halt(halt), .duty_main(duty_main),
    .isw_a(isw_a), .isw_b(isw_b), .bal_tick(bal_tick),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  // behavioural reference
  int m_t = 0, m_integ = 0, m_corr = 0, m_la = 0, m_lb = 0;
  bit m_pa = 0, m_pb = 0;

  function automatic int lim(int v, int lo, int hi);
    return v < lo ? lo : (v > hi ? hi : v);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_t = 0; m_integ = 0; m_corr = 0; m_la = 0; m_lb = 0; m_pa = 0; m_pb = 0;
    end else begin
      int pb, na, nb, ua, ub, e;
      pb = (m_t + H) % P;
      na = lim(int'(duty_main) + m_corr, DLO, DHI);
      nb = lim(int'(duty_main) - m_corr, DLO, DHI);
      ua = (m_t == 0) ? na : m_la;
      ub = (pb == 0) ? nb : m_lb;
      m_pa = !halt && (m_t < ua);
      m_pb = !halt && (pb < ub);
      m_la = ua;
      m_lb = ub;
      if (halt) begin
        m_integ = 0; m_corr = 0;
      end else if (bal_tick) begin
        e = int'(isw_a) - int'(isw_b);
        m_integ = lim(m_integ + e, -IL, IL);
        m_corr = lim((e >>> KP) + (m_integ >>> KI), -CL, CL);
      end
      m_t = (m_t + 1) % P;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R6 R10 pwm_a vs model", int'(pwm_a), int'(m_pa));
      check("R6 R10 pwm_b vs model", int'(pwm_b), int'(m_pb));
    end
  end

  task automatic strobe();
    @(negedge clk); bal_tick = 1'b1;
    @(negedge clk); bal_tick = 1'b0;
  endtask

  task automatic measure(input string req, input int exp_a, input int exp_b);
    int na = 0, nb = 0;
    repeat (2 * P) @(negedge clk);
    repeat (P) begin
      @(negedge clk);
      na += int'(pwm_a);
      nb += int'(pwm_b);
    end
    check({req, " high count a"}, na, exp_a);
    check({req, " high count b"}, nb, exp_b);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pwm_a low", int'(pwm_a), 0);
    check("R1 reset pwm_b low", int'(pwm_b), 0);
    rst_n = 1'b1;

    measure("R1 equal currents", 20, 20);
    begin : phase_gap
      int ta, tb;
      while (pwm_a) @(negedge clk);
      while (!pwm_a) @(negedge clk);
      ta = cyc;
      while (!pwm_b) @(negedge clk);
      tb = cyc;
      check("R1 lag of pwm_b rise", tb - ta, H);
    end

    // R9: diff +20 -> integ 20, corr 10+2=12
    isw_a = UW'(520); strobe();
    measure("R9 positive imbalance", 32, 8);
    duty_main = CW'(30);
    measure("R3 upper clamp", 36, 18);
    duty_main = CW'(4);
    measure("R3 lower clamp", 16, 2);
    // R9 sign: diff -20 -> integ 0, corr -10
    duty_main = CW'(20); isw_a = UW'(480); strobe();
    measure("R9 negative imbalance", 10, 30);

    // R6: mid-period main duty change is tracked by the model compare
    repeat (7) @(negedge clk);
    duty_main = CW'(25);
    repeat (P / 3) @(negedge clk);
    duty_main = CW'(20);

    halt = 1'b1;
    measure("R2 halted", 0, 0);
    halt = 1'b0;
    measure("R7 after halt", 20, 20);

    // R4: five strobes of +100 saturate integ at 64; then e=0 -> corr 8
    isw_a = UW'(600);
    repeat (5) strobe();
    isw_a = UW'(500); strobe();
    measure("R4 integrator limit", 28, 12);
    isw_a = UW'(900);
    measure("R5 no strobe no change", 28, 12);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

endmodule